// File: doc/BRIEF.md
# Low-Side Diode Emulation Controller

This block sits between the PWM command decoder and the low-side gate driver of a synchronous buck power stage. It decides, cycle by cycle, whether the low-side switch may conduct. In continuous mode the low side is the plain complement of the PWM command. In diode emulation mode the low side turns off when the inductor current crosses zero, so the converter runs in discontinuous conduction at light load. `dem_active` reports which mode is in effect.

A PWM period runs from one rising edge of `pwm_cmd` to the next. While `ccm_sel_async` is low, the block watches `zc_async`, a flag from the current comparator. It enters emulation only after three periods in a row each carried a zero-cross event. It leaves emulation at a rising PWM edge: either continuous mode was requested, or the period that just ended had no zero-cross. Both asynchronous inputs pass through two-flop synchronizers first.

The controller has five states. CONT is continuous mode. DEM_HIGH covers the high-side phase in emulation. DEM_BLANK is the enforced minimum low-side on time. DEM_ON is the low-side conduction phase, where a zero-cross may stop conduction. DEM_LATCH holds the low side off until the next period.

The transitions are:
- CONT to DEM_HIGH on arming.
- DEM_HIGH to DEM_BLANK on a falling PWM edge. This goes straight to DEM_ON when the minimum on time is zero.
- DEM_BLANK to DEM_ON when the blanking timer expires.
- DEM_ON to DEM_LATCH on a zero-cross while continuous mode is not selected.
- From any emulation state, on a rising PWM edge: back to DEM_HIGH if the period had a zero-cross, otherwise to CONT. A rising edge also goes to CONT whenever continuous mode is selected.

Top module: `lsgate_dem_ctrl`

## Requirements
- R1: After reset `dem_active` is 0 and `ls_gate_en` equals the inverse of `pwm_cmd`.
- R2: While the synchronized mode select is high, `dem_active` stays 0 and `ls_gate_en` is `!pwm_cmd` in every cycle. Zero-cross events in this state neither arm emulation nor change the gate.
- R3: Consider three consecutive PWM periods, each containing a synchronized zero-cross while the mode select is low. `dem_active` rises one clock after the rising PWM edge that ends the third of them.
- R4: A period without a zero-cross clears the run. Emulation then needs three further consecutive zero-cross periods.
- R5: In emulation, a period that ends without a zero-cross returns the block to continuous mode. `dem_active` falls one clock after the rising edge that ends that period.
- R6: In emulation, `ls_gate_en` is 0 while `pwm_cmd` is 1 and in the first low cycle after a falling edge. After that it is 1 until a latch occurs. `ls_gate_en` and `pwm_cmd` are never both 1.
- R7: In emulation, a synchronized zero-cross seen in DEM_ON drives `ls_gate_en` to 0 one clock later. It stays 0 until the next rising PWM edge, and the next low phase enables the gate again.
- R8: In emulation, a zero-cross that arrives during the first MIN_ON_CYC (default 4) cycles of low-side conduction does not latch the gate off. It still counts as a zero-cross for the period.
- R9: If the mode select goes high during emulation, the present state holds until the next rising PWM edge. A latched-off gate stays off, and no new latch is made. At that edge the block enters CONT.
- R10: `zc_async` and `ccm_sel_async` act after two clock cycles of synchronization. A zero-cross pulse driven in low-phase cycle j (with j of at least 3) latches the gate off from low-phase cycle j+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmd | input | 1 | Decoded PWM command, 1 = high side on |
| ccm_sel_async | input | 1 | Mode select, 1 forces continuous mode, asynchronous |
| zc_async | input | 1 | Zero-cross flag from the current comparator, asynchronous |
| ls_gate_en | output | 1 | Permission for the low-side gate to conduct |
| dem_active | output | 1 | 1 while diode emulation is in effect |

## Verification
A wrong run count shows up at `dem_active`. Its rise appears one PWM period early or late, or not at all, and the error is visible one clock after the deciding rising edge. A wrong blanking, latch or exit state shows up at `ls_gate_en` within the low phase where it goes wrong. It appears as a gate that turns off too early, turns off too late, or fails to reopen in the next period. The bench compares both outputs in every cycle of a long sequence of periods. The sequence covers arming, a broken run, latch boundaries and mode changes.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [2:0] {
        ST_CONT      = 3'd0,
        ST_DEM_HIGH  = 3'd1,
        ST_DEM_BLANK = 3'd2,
        ST_DEM_ON    = 3'd3,
        ST_DEM_LATCH = 3'd4
    } lsm_state_e;

endpackage

// File: rtl/lsm_sync.sv
module lsm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/lsm_run_counter.sv
module lsm_run_counter #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_rise,
    input  logic zc_s,
    input  logic ccm_s,
    output logic period_hit,
    output logic run_done
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

    logic             zc_seen_q;
    logic             zc_now;
    logic [CNT_W-1:0] run_q;

    // zero-cross detection only while continuous mode is not selected
    assign zc_now     = zc_s & ~ccm_s;
    assign period_hit = zc_seen_q | zc_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        zc_seen_q <= 1'b0;
        else if (pwm_rise) zc_seen_q <= 1'b0;
        else if (zc_now)   zc_seen_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (pwm_rise) begin
            if (ccm_s || !period_hit) run_q <= '0;
            else if (run_q != CNT_FULL) run_q <= run_q + 1'b1;
        end
    end

    assign run_done = pwm_rise & ~ccm_s & period_hit & (run_q >= CNT_LAST);

endmodule

// File: rtl/lsm_blank_timer.sv
module lsm_blank_timer #(
    parameter int MIN_ON = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    generate
        if (MIN_ON == 0) begin : g_none
            assign done = run;
        end else begin : g_cnt
            localparam int T_W = $clog2(MIN_ON + 1);
            localparam logic [T_W-1:0] T_LAST = T_W'(MIN_ON - 1);
            logic [T_W-1:0] tick_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   tick_q <= '0;
                else if (run) tick_q <= tick_q + 1'b1;
                else          tick_q <= '0;
            end

            assign done = run && (tick_q == T_LAST);
        end
    endgenerate

endmodule

// File: rtl/lsgate_dem_ctrl.sv
module lsgate_dem_ctrl
    import lsm_pkg::*;
#(
    parameter int MIN_ON_CYC  = 4,
    parameter int RUN_LEN     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_cmd,
    input  logic ccm_sel_async,
    input  logic zc_async,
    output logic ls_gate_en,
    output logic dem_active
);

    localparam bit HAS_BLANK = (MIN_ON_CYC > 0);

    lsm_state_e state_q;
    lsm_state_e state_d;

    logic [1:0] async_in;
    logic [1:0] sync_out;
    logic       ccm_s;
    logic       zc_s;
    logic       pwm_d;
    logic       pwm_rise;
    logic       pwm_fall;
    logic       period_hit;
    logic       run_done;
    logic       blank_done;

    assign async_in = {ccm_sel_async, zc_async};

    lsm_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (async_in),
        .dout  (sync_out)
    );

    assign ccm_s = sync_out[1];
    assign zc_s  = sync_out[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_d <= 1'b0;
        else        pwm_d <= pwm_cmd;
    end

    assign pwm_rise = pwm_cmd & ~pwm_d;
    assign pwm_fall = ~pwm_cmd & pwm_d;

    lsm_run_counter #(
        .RUN_LEN (RUN_LEN)
    ) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_rise   (pwm_rise),
        .zc_s       (zc_s),
        .ccm_s      (ccm_s),
        .period_hit (period_hit),
        .run_done   (run_done)
    );

    lsm_blank_timer #(
        .MIN_ON (MIN_ON_CYC)
    ) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_DEM_BLANK),
        .done  (blank_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CONT: begin
                if (run_done) state_d = ST_DEM_HIGH;
            end
            ST_DEM_HIGH: begin
                if (pwm_rise)
                    state_d = (ccm_s || !period_hit) ? ST_CONT : ST_DEM_HIGH;
                else if (pwm_fall)
                    state_d = HAS_BLANK ? ST_DEM_BLANK : ST_DEM_ON;
            end
            ST_DEM_BLANK: begin
                if (pwm_rise)
                    state_d = (ccm_s || !period_hit) ? ST_CONT : ST_DEM_HIGH;
                else if (blank_done)
                    state_d = ST_DEM_ON;
            end
            ST_DEM_ON: begin
                if (pwm_rise)
                    state_d = (ccm_s || !period_hit) ? ST_CONT : ST_DEM_HIGH;
                else if (zc_s && !ccm_s)
                    state_d = ST_DEM_LATCH;
            end
            ST_DEM_LATCH: begin
                if (pwm_rise)
                    state_d = (ccm_s || !period_hit) ? ST_CONT : ST_DEM_HIGH;
            end
            default: state_d = ST_CONT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CONT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        ls_gate_en = 1'b0;
        dem_active = 1'b1;
        unique case (state_q)
            ST_CONT: begin
                ls_gate_en = ~pwm_cmd;
                dem_active = 1'b0;
            end
            ST_DEM_HIGH:  ls_gate_en = 1'b0;
            ST_DEM_BLANK: ls_gate_en = ~pwm_cmd;
            ST_DEM_ON:    ls_gate_en = ~pwm_cmd;
            ST_DEM_LATCH: ls_gate_en = 1'b0;
            default: begin
                ls_gate_en = 1'b0;
                dem_active = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lsm_dem_checker.sv
module lsm_dem_checker
    import lsm_pkg::*;
#(
    parameter int MIN_ON_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pwm_cmd,
    input logic       ls_gate_en,
    input logic       dem_active,
    input lsm_state_e state,
    input logic       pwm_rise
);

    logic [15:0] on_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      on_cnt_q <= '0;
        else if (!ls_gate_en)            on_cnt_q <= '0;
        else if (on_cnt_q != 16'hFFFF)   on_cnt_q <= on_cnt_q + 16'd1;
    end

    assert_cont_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dem_active |-> (ls_gate_en == !pwm_cmd));

    assert_entry_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dem_active) |-> ($past(pwm_cmd) && !$past(pwm_cmd, 2)));

    assert_exit_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dem_active) |-> ($past(pwm_cmd) && !$past(pwm_cmd, 2)));

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_cmd |-> !ls_gate_en);

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEM_LATCH && !pwm_rise) |=> (state == ST_DEM_LATCH));

    assert_min_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dem_active && !pwm_cmd && $fell(ls_gate_en)) |-> (on_cnt_q >= 16'(MIN_ON_CYC)));

endmodule

bind lsgate_dem_ctrl lsm_dem_checker #(
    .MIN_ON_CYC (MIN_ON_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_cmd    (pwm_cmd),
    .ls_gate_en (ls_gate_en),
    .dem_active (dem_active),
    .state      (state_q),
    .pwm_rise   (pwm_rise)
);

// File: tb/sim_lsgate_dem_ctrl.sv
`timescale 1ns/1ps
module sim_lsgate_dem_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_cmd = 1'b0;
    logic ccm_sel_async = 1'b0;
    logic zc_async = 1'b0;
    logic ls_gate_en;
    logic dem_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit    exp_ls_q[$];
    bit    exp_emu_q[$];
    string exp_tag_q[$];

    always #2 clk = ~clk;

    lsgate_dem_ctrl u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwm_cmd       (pwm_cmd),
        .ccm_sel_async (ccm_sel_async),
        .zc_async      (zc_async),
        .ls_gate_en    (ls_gate_en),
        .dem_active    (dem_active)
    );

    task automatic push_exp(input bit ls, input bit emu, input string tag);
        exp_ls_q.push_back(ls);
        exp_emu_q.push_back(emu);
        exp_tag_q.push_back(tag);
    endtask

    // monitor: compares one expected item per cycle, away from the rising edge
    always @(negedge clk) begin
        if (exp_ls_q.size() > 0) begin
            bit    e_ls;
            bit    e_emu;
            string t;
            e_ls  = exp_ls_q.pop_front();
            e_emu = exp_emu_q.pop_front();
            t     = exp_tag_q.pop_front();
            checks++;
            if (ls_gate_en !== e_ls || dem_active !== e_emu) begin
                errors++;
                $display("FAIL %s at %0t: ls_gate_en=%b exp %b dem_active=%b exp %b",
                         t, $time, ls_gate_en, e_ls, dem_active, e_emu);
            end
        end
    end

    // one PWM period: h high cycles, then l low cycles
    // zc_idx: low-phase cycle of a one-cycle zero-cross pulse (-1 none)
    // ccm_late: low-phase cycle from which mode select is driven high (-1 none)
    // latch_idx: first low-phase cycle with the gate expected latched off (-1 none)
    task automatic run_period(input int h, input int l, input int zc_idx,
                              input bit ccm_v, input int ccm_late,
                              input bit emu0, input bit emu1, input bit dem,
                              input int latch_idx, input string tag);
        for (int i = 0; i < h; i++) begin
            @(posedge clk); #1;
            pwm_cmd       = 1'b1;
            zc_async      = 1'b0;
            ccm_sel_async = ccm_v;
            push_exp(1'b0, (i == 0) ? emu0 : emu1, tag);
        end
        for (int k = 0; k < l; k++) begin
            bit e_ls;
            @(posedge clk); #1;
            pwm_cmd       = 1'b0;
            zc_async      = (k == zc_idx);
            ccm_sel_async = (ccm_late >= 0 && k >= ccm_late) ? 1'b1 : ccm_v;
            if (!dem)                                e_ls = 1'b1;
            else if (k == 0)                         e_ls = 1'b0;
            else if (latch_idx >= 0 && k >= latch_idx) e_ls = 1'b0;
            else                                     e_ls = 1'b1;
            push_exp(e_ls, emu1, tag);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        push_exp(1'b1, 1'b0, "R1 in reset");
        @(posedge clk); #1;
        rst_n = 1'b1;
        push_exp(1'b1, 1'b0, "R1 after reset");
        @(posedge clk); #1;
        push_exp(1'b1, 1'b0, "R1 idle");

        // arming after three zero-cross periods
        run_period(4, 12,  6, 0, -1, 0, 0, 0, -1, "R3 run first");
        run_period(4, 12,  6, 0, -1, 0, 0, 0, -1, "R3 run second");
        run_period(4, 12,  6, 0, -1, 0, 0, 0, -1, "R3 run third");
        run_period(4, 12,  6, 0, -1, 0, 1, 1,  9, "R3 R6 R7 R10 armed");
        run_period(4, 12,  6, 0, -1, 1, 1, 1,  9, "R7 latch cleared by edge");
        run_period(2, 12,  3, 0, -1, 1, 1, 1,  6, "R8 first latchable cycle");
        run_period(4, 12,  2, 0, -1, 1, 1, 1, -1, "R8 zero-cross in blanking");
        run_period(4, 12, -1, 0, -1, 1, 1, 1, -1, "R5 period without zero-cross");
        run_period(4, 12,  6, 0, -1, 1, 0, 0, -1, "R5 back to continuous");

        // broken run
        run_period(4, 12,  6, 0, -1, 0, 0, 0, -1, "R4 run second");
        run_period(4, 12, -1, 0, -1, 0, 0, 0, -1, "R4 break");
        run_period(3, 10,  5, 0, -1, 0, 0, 0, -1, "R4 fresh first");
        run_period(4, 12,  6, 0, -1, 0, 0, 0, -1, "R4 fresh second");
        run_period(4, 12,  6, 0, -1, 0, 0, 0, -1, "R4 fresh third");
        run_period(4, 12,  6, 0, -1, 0, 1, 1,  9, "R4 rearmed");

        // mode select raised while latched off
        run_period(4, 12,  6, 0,  8, 1, 1, 1,  9, "R9 latch held with mode select high");
        run_period(4, 12,  6, 1, -1, 1, 0, 0, -1, "R9 continuous after edge");

        // continuous mode forced
        run_period(4, 12,  6, 1, -1, 0, 0, 0, -1, "R2 zero-cross ignored");
        run_period(5,  8,  4, 1, -1, 0, 0, 0, -1, "R2 zero-cross ignored");
        run_period(4, 12,  6, 1, -1, 0, 0, 0, -1, "R2 zero-cross ignored");
        run_period(4, 12,  6, 1, -1, 0, 0, 0, -1, "R2 no arming");

        // release mode select and rearm
        run_period(4, 12,  6, 0, -1, 0, 0, 0, -1, "R2 release first");
        run_period(4, 12,  6, 0, -1, 0, 0, 0, -1, "R3 second after release");
        run_period(4, 12,  6, 0, -1, 0, 0, 0, -1, "R3 third after release");
        run_period(4, 12,  6, 0, -1, 0, 1, 1,  9, "R3 armed after release");

        // mode select raised while gate on
        run_period(4, 12,  6, 1, -1, 1, 1, 1, -1, "R9 no new latch");
        run_period(4, 12, -1, 1, -1, 1, 0, 0, -1, "R9 continuous resumes");

        @(posedge clk); #1;
        push_exp(1'b1, 1'b0, "R2 idle end");
        while (exp_ls_q.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule